// File: doc/BRIEF.md
# Reservation Monitor for Conditional Stores

This block sits in front of a small word-addressed shared memory used by several cores. It lets software build locks and other atomic updates without holding the memory across two accesses. A core first issues a linked read. The read returns the word and arms a reservation for that core, made of a flag and the reserved word address. Later the core issues a conditional write to the same word. The write lands only if the reservation survived, and the core gets back 1 on success or 0 on failure.

Between those two accesses the memory stays fully available to every core. A reservation is killed by any of the following:
- a write to the reserved word by another core, either a plain store or a successful conditional write;
- a write to that word seen on the snoop input from elsewhere in the coherence domain;
- an interrupt or context-switch pulse for the owning core;
- the owning core's own conditional write, whatever its outcome.

The cores share one access slot per cycle. A fixed-priority arbiter grants it combinationally, and the response comes back one cycle later.

Top module: `llsc_monitor`

## Requirements
- R1: A granted request produces `respValid` equal to the one-hot grant of the previous cycle. For a plain read (op 2'b00) or a linked read (op 2'b10), `respData` is the memory word at the request address as it stood before that cycle's update.
- R2: Among the asserting cores, the lowest-numbered one is granted in the same cycle, and at most one grant is active per cycle. A request that is not granted has no effect and must be held until it is granted.
- R3: A linked read arms the issuing core's reservation on the request address. A following conditional write (op 2'b11) by that core to the same address, with no kill in between, writes the data and returns `respData` = 1 (bit 0 set, all other bits 0).
- R4: A conditional write whose reservation is not armed returns `respData` = 0 and leaves memory unchanged.
- R5: A conditional write to an address other than the reserved one fails, returns 0 and leaves memory unchanged.
- R6: Every conditional write disarms the issuing core's reservation, whether it passes or fails, so an immediately repeated conditional write fails.
- R7: A plain store (op 2'b01) by another core to the reserved word disarms the reservation. A store to a different word, or a store by the owning core itself, does not.
- R8: A successful conditional write by one core disarms the matching reservations of all other cores.
- R9: A cycle with `snoopValid` high disarms every reservation whose address equals `snoopAddr`. Reservations on other words are untouched.
- R10: `intrKill[k]` disarms only core k's reservation.
- R11: A linked read granted in the same cycle as a kill aimed at the same core (interrupt or snoop) leaves that reservation armed.
- R12: After reset, every memory word reads 0, no reservation is armed, and `respValid` is 0.
- R13: A plain store writes its data to memory and returns `respData` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reqValid | input | N | Per-core request strobe |
| reqOp | input | 2*N | Per-core operation: 00 read, 01 store, 10 linked read, 11 conditional write |
| reqAddr | input | AW*N | Per-core word address |
| reqData | input | DW*N | Per-core write data |
| grant | output | N | One-hot grant, same cycle as the request |
| intrKill | input | N | Per-core interrupt or context-switch pulse |
| snoopValid | input | 1 | A write elsewhere in the coherence domain |
| snoopAddr | input | AW | Word address of that write |
| respValid | output | N | One-hot response strobe, one cycle after grant |
| respData | output | DW | Read data, or conditional-write result in bit 0 |

## Verification
The hardest situations to reach are those where a kill and a re-arm meet on the same core. Examples are a linked read granted in the very cycle its core's interrupt or a matching snoop fires, and a kill that must spare a neighbouring reservation on another word. Reservation state is not visible at the ports, so the bench reads it back through the outcome of a later conditional write.

For every ordered pair of distinct cores, the bench runs a set of short scripted sequences. Each sequence arms, perturbs and then probes the reservation. A requirement-level model predicts every response.

// File: rtl/llsc_pkg.sv
package llsc_pkg;

  typedef enum logic [1:0] {
    OP_READ  = 2'b00,
    OP_STORE = 2'b01,
    OP_LINK  = 2'b10,
    OP_COND  = 2'b11
  } memOp_e;

  // strobes from control to datapath for the granted access
  typedef struct packed {
    logic fire;      // some core holds the slot this cycle
    logic rdEn;      // return memory word
    logic wrEn;      // memory write lands (store or passing conditional)
    logic link;      // arm reservation of the granted core
    logic cond;      // conditional write attempted
    logic condPass;  // conditional write succeeds
  } strobe_t;

endpackage

// File: rtl/llsc_ctrl.sv
module llsc_ctrl
  import llsc_pkg::*;
#(
  parameter int N  = 4,
  parameter int AW = 4,
  parameter int DW = 8
) (
  input  logic [N-1:0]        reqValid,
  input  logic [2*N-1:0]      reqOp,
  input  logic [AW*N-1:0]     reqAddr,
  input  logic [DW*N-1:0]     reqData,
  input  logic [N-1:0]        resvFlag,
  input  logic [AW*N-1:0]     resvAddr,
  output logic [N-1:0]        grant,
  output strobe_t             strb,
  output logic [AW-1:0]       selAddr,
  output logic [DW-1:0]       selData
);

  localparam int IW = (N > 1) ? $clog2(N) : 1;

  logic [IW-1:0] selIdx;
  logic          anyReq;
  memOp_e        selOp;
  logic          selFlag;
  logic [AW-1:0] selResv;

  // fixed priority: lowest index wins
  always_comb begin
    selIdx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (reqValid[i]) selIdx = IW'(i);
    end
  end

  assign anyReq  = |reqValid;
  assign grant   = anyReq ? (N'(1) << selIdx) : '0;
  assign selOp   = memOp_e'(reqOp[selIdx*2 +: 2]);
  assign selAddr = reqAddr[selIdx*AW +: AW];
  assign selData = reqData[selIdx*DW +: DW];
  assign selFlag = resvFlag[selIdx];
  assign selResv = resvAddr[selIdx*AW +: AW];

  always_comb begin
    strb          = '0;
    strb.fire     = anyReq;
    strb.rdEn     = anyReq && (selOp == OP_READ || selOp == OP_LINK);
    strb.link     = anyReq && (selOp == OP_LINK);
    strb.cond     = anyReq && (selOp == OP_COND);
    strb.condPass = strb.cond && selFlag && (selResv == selAddr);
    strb.wrEn     = (anyReq && selOp == OP_STORE) || strb.condPass;
  end

endmodule

// File: rtl/llsc_dpath.sv
module llsc_dpath
  import llsc_pkg::*;
#(
  parameter int N  = 4,
  parameter int AW = 4,
  parameter int DW = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  strobe_t             strb,
  input  logic [N-1:0]        grant,
  input  logic [AW-1:0]       selAddr,
  input  logic [DW-1:0]       selData,
  input  logic [N-1:0]        intrKill,
  input  logic                snoopValid,
  input  logic [AW-1:0]       snoopAddr,
  output logic [N-1:0]        resvFlag,
  output logic [AW*N-1:0]     resvAddr,
  output logic [N-1:0]        respValid,
  output logic [DW-1:0]       respData
);

  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int w = 0; w < DEPTH; w++) mem[w] <= '0;
    end else if (strb.wrEn) begin
      mem[selAddr] <= selData;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      respValid <= '0;
      respData  <= '0;
    end else begin
      respValid <= grant;
      if (strb.rdEn) respData <= mem[selAddr];
      else           respData <= {{(DW-1){1'b0}}, strb.condPass};
    end
  end

  for (genvar k = 0; k < N; k++) begin : g_resv
    logic          flagQ;
    logic [AW-1:0] addrQ;
    logic          ownLink, ownCond, remoteHit, snoopHit;

    assign ownLink   = strb.link && grant[k];
    assign ownCond   = strb.cond && grant[k];
    assign remoteHit = strb.wrEn && !grant[k] && (addrQ == selAddr);
    assign snoopHit  = snoopValid && (addrQ == snoopAddr);

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        flagQ <= 1'b0;
        addrQ <= '0;
      end else if (ownLink) begin
        flagQ <= 1'b1;
        addrQ <= selAddr;
      end else if (intrKill[k] || ownCond || remoteHit || snoopHit) begin
        flagQ <= 1'b0;
      end
    end

    assign resvFlag[k]             = flagQ;
    assign resvAddr[k*AW +: AW]    = addrQ;
  end

endmodule

// File: rtl/llsc_monitor.sv
module llsc_monitor
  import llsc_pkg::*;
#(
  parameter int N  = 4,
  parameter int AW = 4,
  parameter int DW = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [N-1:0]        reqValid,
  input  logic [2*N-1:0]      reqOp,
  input  logic [AW*N-1:0]     reqAddr,
  input  logic [DW*N-1:0]     reqData,
  output logic [N-1:0]        grant,
  input  logic [N-1:0]        intrKill,
  input  logic                snoopValid,
  input  logic [AW-1:0]       snoopAddr,
  output logic [N-1:0]        respValid,
  output logic [DW-1:0]       respData
);

  strobe_t        strb;
  logic [AW-1:0]  selAddr;
  logic [DW-1:0]  selData;
  logic [N-1:0]   resvFlag;
  logic [AW*N-1:0] resvAddr;

  llsc_ctrl #(.N(N), .AW(AW), .DW(DW)) u_ctrl (
    .reqValid (reqValid),
    .reqOp    (reqOp),
    .reqAddr  (reqAddr),
    .reqData  (reqData),
    .resvFlag (resvFlag),
    .resvAddr (resvAddr),
    .grant    (grant),
    .strb     (strb),
    .selAddr  (selAddr),
    .selData  (selData)
  );

  llsc_dpath #(.N(N), .AW(AW), .DW(DW)) u_dpath (
    .clk        (clk),
    .rst_n      (rst_n),
    .strb       (strb),
    .grant      (grant),
    .selAddr    (selAddr),
    .selData    (selData),
    .intrKill   (intrKill),
    .snoopValid (snoopValid),
    .snoopAddr  (snoopAddr),
    .resvFlag   (resvFlag),
    .resvAddr   (resvAddr),
    .respValid  (respValid),
    .respData   (respData)
  );

endmodule

// File: rtl/llsc_monitor_chk.sv
module llsc_monitor_chk #(
  parameter int N  = 4,
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic [N-1:0]  reqValid,
  input logic [N-1:0]  grant,
  input logic [N-1:0]  respValid,
  input logic [DW-1:0] respData,
  input logic [N-1:0]  intrKill,
  input logic [N-1:0]  resvFlag,
  input logic          linkNow,
  input logic          condNow
);

  a_r2_grant_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));

  a_r2_grant_requested: assert property (@(posedge clk) disable iff (!rst_n)
    (grant & ~reqValid) == '0);

  a_r1_resp_follows_grant: assert property (@(posedge clk) disable iff (!rst_n)
    (|grant) |=> (respValid == $past(grant)));

  for (genvar k = 0; k < N; k++) begin : g_core
    a_r10_intr_disarms: assert property (@(posedge clk) disable iff (!rst_n)
      (intrKill[k] && !(grant[k] && linkNow)) |=> !resvFlag[k]);

    a_r11_link_arms: assert property (@(posedge clk) disable iff (!rst_n)
      (grant[k] && linkNow) |=> resvFlag[k]);

    a_r6_cond_disarms: assert property (@(posedge clk) disable iff (!rst_n)
      (grant[k] && condNow) |=> !resvFlag[k]);

    a_r4_unarmed_fails: assert property (@(posedge clk) disable iff (!rst_n)
      (grant[k] && condNow && !resvFlag[k]) |=> (respData == '0));
  end

endmodule

bind llsc_monitor llsc_monitor_chk #(.N(N), .DW(DW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .reqValid  (reqValid),
  .grant     (grant),
  .respValid (respValid),
  .respData  (respData),
  .intrKill  (intrKill),
  .resvFlag  (resvFlag),
  .linkNow   (strb.link),
  .condNow   (strb.cond)
);

// File: tb/sim_llsc_monitor.sv
`timescale 1ns/1ps
module sim_llsc_monitor;

  localparam int N  = 4;
  localparam int AW = 4;
  localparam int DW = 8;
  localparam int DEPTH = 1 << AW;
  localparam logic [1:0] RD = 2'b00, ST = 2'b01, LL = 2'b10, SC = 2'b11;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [N-1:0]    reqValid = '0;
  logic [2*N-1:0]  reqOp = '0;
  logic [AW*N-1:0] reqAddr = '0;
  logic [DW*N-1:0] reqData = '0;
  logic [N-1:0]    grant;
  logic [N-1:0]    intrKill = '0;
  logic            snoopValid = 1'b0;
  logic [AW-1:0]   snoopAddr = '0;
  logic [N-1:0]    respValid;
  logic [DW-1:0]   respData;

  int checks = 0;
  int fails  = 0;

  int mMem  [DEPTH];
  bit mFlag [N];
  int mAddr [N];

  always #2 clk = ~clk;

  llsc_monitor #(.N(N), .AW(AW), .DW(DW)) u0 (
    .clk(clk), .rst_n(rst_n), .reqValid(reqValid), .reqOp(reqOp),
    .reqAddr(reqAddr), .reqData(reqData), .grant(grant),
    .intrKill(intrKill), .snoopValid(snoopValid), .snoopAddr(snoopAddr),
    .respValid(respValid), .respData(respData)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  // one access by core c, with optional kills in the same cycle
  task automatic doOp(input int c, input logic [1:0] opc, input int a, input int d,
                      input logic [N-1:0] kill, input bit sv, input int sa,
                      input string tag);
    int  exp;
    bit  pass;
    bit  wr;
    reqValid = '0;
    reqValid[c] = 1'b1;
    reqOp[c*2 +: 2]    = opc;
    reqAddr[c*AW +: AW] = AW'(a);
    reqData[c*DW +: DW] = DW'(d);
    intrKill   = kill;
    snoopValid = sv;
    snoopAddr  = AW'(sa);
    pass = (opc == SC) && mFlag[c] && (mAddr[c] == a);
    if (opc == RD || opc == LL) exp = mMem[a];
    else                        exp = pass ? 1 : 0;
    wr = (opc == ST) || pass;
    #1;
    check(grant == N'(1 << c), "R2", int'(grant), 1 << c);
    @(posedge clk);
    for (int k = 0; k < N; k++) begin
      if (k == c && opc == LL) begin mFlag[k] = 1; mAddr[k] = a; end
      else if (kill[k]) mFlag[k] = 0;
      else if (k == c && opc == SC) mFlag[k] = 0;
      else if (wr && k != c && mAddr[k] == a) mFlag[k] = 0;
      else if (sv && mAddr[k] == sa) mFlag[k] = 0;
    end
    if (wr) mMem[a] = d & 8'hff;
    @(negedge clk);
    reqValid = '0; intrKill = '0; snoopValid = 1'b0;
    check(respValid == N'(1 << c), "R1", int'(respValid), 1 << c);
    check(int'(respData) == exp, tag, int'(respData), exp);
  endtask

  task automatic op(input int c, input logic [1:0] opc, input int a, input int d,
                    input string tag);
    doOp(c, opc, a, d, '0, 1'b0, 0, tag);
  endtask

  initial begin
    #(4 * 150000);
    checks++; fails++;
    $display("FAIL watchdog actual=hung expected=done");
    summary();
  end

  initial begin
    for (int w = 0; w < DEPTH; w++) mMem[w] = 0;
    for (int k = 0; k < N; k++) begin mFlag[k] = 0; mAddr[k] = 0; end
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    check(respValid == '0, "R12", int'(respValid), 0);
    check(grant == '0, "R12", int'(grant), 0);

    // R12: every word reads zero after reset
    for (int w = 0; w < DEPTH; w++) op(0, RD, w, 0, "R12");
    // R12: no reservation armed after reset
    for (int c = 0; c < N; c++) op(c, SC, 0, 8'h5a, "R12");
    op(1, RD, 0, 0, "R12");

    // R2: contention, lowest index wins, loser held
    reqValid = 4'b1010;
    reqOp    = {ST, 2'b00, ST, 2'b00};
    reqAddr[1*AW +: AW] = 4'd5; reqData[1*DW +: DW] = 8'h11;
    reqAddr[3*AW +: AW] = 4'd5; reqData[3*DW +: DW] = 8'h22;
    #1 check(grant == 4'b0010, "R2", int'(grant), 2);
    @(negedge clk);
    check(respValid == 4'b0010, "R2", int'(respValid), 2);
    reqValid = 4'b1000;
    #1 check(grant == 4'b1000, "R2", int'(grant), 8);
    @(negedge clk);
    reqValid = '0;
    check(respValid == 4'b1000, "R2", int'(respValid), 8);
    mMem[5] = 8'h22;
    op(0, RD, 5, 0, "R2");

    // R13: plain stores and read-back
    for (int w = 0; w < DEPTH; w++) op(w % N, ST, w, 8'h80 + w, "R13");
    for (int w = 0; w < DEPTH; w++) op((w + 1) % N, RD, w, 0, "R1");

    for (int c = 0; c < N; c++) begin
      for (int j = 0; j < N; j++) begin
        if (j != c) begin
          int a, b, d;
          a = (c * 4 + j) % DEPTH;
          b = a ^ 1;
          d = c * 16 + j * 3;
          // R3 success path
          op(c, LL, a, 0, "R1");
          op(c, SC, a, d + 1, "R3");
          op(j, RD, a, 0, "R3");
          // R7 remote store to reserved word
          op(c, LL, a, 0, "R1");
          op(j, ST, a, d + 2, "R13");
          op(c, SC, a, d + 3, "R7");
          op(j, RD, a, 0, "R4");
          // R7 remote store elsewhere, then own store
          op(c, LL, a, 0, "R1");
          op(j, ST, b, d + 4, "R13");
          op(c, ST, a, d + 5, "R13");
          op(c, SC, a, d + 6, "R7");
          // R8 other core's passing conditional
          op(c, LL, a, 0, "R1");
          op(j, LL, a, 0, "R1");
          op(j, SC, a, d + 7, "R8");
          op(c, SC, a, d + 8, "R8");
          op(c, RD, a, 0, "R8");
          // R5 wrong address, R6 repeat fails
          op(c, LL, a, 0, "R1");
          op(c, SC, b, d + 9, "R5");
          op(c, RD, b, 0, "R5");
          op(c, SC, a, d + 10, "R6");
          op(c, RD, a, 0, "R6");
          // R10 interrupt hits only its own core
          op(j, LL, a, 0, "R1");
          op(c, LL, a, 0, "R1");
          doOp(j, RD, b, 0, N'(1 << c), 1'b0, 0, "R1");
          op(c, SC, a, d + 11, "R10");
          op(j, SC, a, d + 12, "R10");
          // R9 snoop on one word spares the other
          op(c, LL, a, 0, "R1");
          op(j, LL, b, 0, "R1");
          doOp(c, RD, a, 0, '0, 1'b1, a, "R1");
          op(j, SC, b, d + 13, "R9");
          op(c, SC, a, d + 14, "R9");
          // R11 linked read beats same-cycle interrupt and snoop
          doOp(c, LL, a, 0, N'(1 << c), 1'b1, a, "R1");
          op(c, SC, a, d + 15, "R11");
          op(j, RD, a, 0, "R11");
        end
      end
    end

    summary();
  end

endmodule